// File: doc/BRIEF.md
# Gray-Code Event Frequency Meter

This block counts the rising edges of an input signal that has no timing relation to the system clock, and reports how many edges occurred in each measurement window of fixed length. The edge counter is clocked by the event signal itself and steps through a Gray sequence. Because only one bit moves per step, a sample taken from the system clock domain at any moment is off by at most one count.

A timebase in the system clock domain closes a window every `WINDOW_CYC` cycles. When it does, it sends a restart request to the event domain as a toggle. The Gray count passes through a register chain into the system clock domain. The captured value is decoded to binary by an XOR reduction of each bit with all bits above it, and a one-cycle strobe marks each new reading. The restart request is sent exactly as many cycles before the capture as the count takes to cross the synchronizer. When the event domain applies the restart, it loads the number of edges it has already seen since the request. As a result, no edge is lost or counted twice between windows. With a one-second window the reading is in hertz.

Top module: `gray_freq_meter`

## Requirements
- R1: On every rising edge of `evt_in` that does not apply a restart, exactly one bit of the internal Gray count changes.
- R2: Each reading on `freq_bin` is a plain binary number within ±1 of the count of `evt_in` rising edges in the preceding window of `WINDOW_CYC` clock cycles. With the defaults and a 10 ns clock, the expected value is 2000 ns divided by the event period.
- R3: Successive `freq_vld` pulses are exactly `WINDOW_CYC` clock cycles apart.
- R4: `freq_vld` is high for a single clock cycle per reading.
- R5: `freq_bin` changes only in the cycle in which `freq_vld` is high, and holds its value otherwise.
- R6: While `rst` is high, and in the cycle after, `freq_bin` is zero and `freq_vld` is low. The first pulse arrives on the `WINDOW_CYC + SYNC_STAGES`-th rising clock edge after the first edge that samples `rst` low.
- R7: Each window starts counting from zero. The restart edge loads the Gray code of `SYNC_STAGES + 1`, which credits the edges seen while the request crossed over. At a steady event rate, readings do not accumulate from one window to the next and differ by at most one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the timebase, synchronizer and readout run on its rising edge |
| rst | input | 1 | Active-high reset; synchronous in the clock domain, asynchronous clear in the event domain |
| evt_in | input | 1 | Asynchronous event signal whose rising edges are counted |
| freq_bin | output | CNT_W | Binary edge count of the last completed window |
| freq_vld | output | 1 | One-cycle strobe marking a new reading |

## Verification
The hardest case to reach is the hand-off between windows. The request toggle, the event-domain clear and the synchronized capture must line up, so that the edges arriving while the request crosses over land in the next window. The only visible sign of this is whether the readings are exact. The stimulus drives event periods that divide the 2000 ns window evenly, with a fractional phase offset so that no event edge ever coincides with a clock edge. Any edge lost or counted twice at the hand-off therefore shows up as a steady offset, or as a reading that grows from window to window. Several rates and a reset in mid-run are applied, and readings that straddle a rate change are discarded.

// File: rtl/gfm_pkg.sv
`timescale 1ns/1ps
package gfm_pkg;
   // lowest synchronizer depth that resolves metastability
   localparam int unsigned GFM_MIN_SYNC = 2;

   // shortest window that leaves room for the restart to complete
   function automatic int unsigned gfm_min_window(input int unsigned sync_stages);
      return sync_stages + 3;
   endfunction

   // number of Gray steps credited when the event domain applies a restart
   function automatic int unsigned gfm_restart_credit(input int unsigned sync_stages);
      return sync_stages + 1;
   endfunction
endpackage

// File: rtl/gfm_gray2bin.sv
`timescale 1ns/1ps
module gfm_gray2bin #(
   parameter int unsigned W = 8
) (
   input  logic [W-1:0] gray_i,
   output logic [W-1:0] bin_o
);
   // each binary bit is the XOR of its Gray bit and every bit above it
   for (genvar i = 0; i < W; i++) begin : g_bit
      assign bin_o[i] = ^gray_i[W-1:i];
   end
endmodule

// File: rtl/gfm_gray_counter.sv
`timescale 1ns/1ps
module gfm_gray_counter #(
   parameter int unsigned W           = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic         evt_clk,
   input  logic         arst,
   input  logic         req_tgl,
   output logic [W-1:0] cnt_gray,
   output logic         restart
);
   import gfm_pkg::*;

   localparam logic [W-1:0] LOAD_BIN  = W'(gfm_restart_credit(SYNC_STAGES));
   localparam logic [W-1:0] LOAD_GRAY = LOAD_BIN ^ (LOAD_BIN >> 1);

   logic [SYNC_STAGES-1:0] req_sync;
   logic                   req_seen;
   logic [W-1:0]           cur_bin;
   logic [W-1:0]           nxt_bin;

   always_ff @(posedge evt_clk or posedge arst) begin
      if (arst) begin
         req_sync <= '0;
         req_seen <= 1'b0;
      end else begin
         req_sync <= {req_sync[SYNC_STAGES-2:0], req_tgl};
         req_seen <= req_sync[SYNC_STAGES-1];
      end
   end

   assign restart = req_sync[SYNC_STAGES-1] ^ req_seen;

   gfm_gray2bin #(.W(W)) u_dec (
      .gray_i (cnt_gray),
      .bin_o  (cur_bin)
   );

   assign nxt_bin = cur_bin + W'(1);

   always_ff @(posedge evt_clk or posedge arst) begin
      if (arst) begin
         cnt_gray <= '0;
      end else if (restart) begin
         cnt_gray <= LOAD_GRAY;
      end else begin
         cnt_gray <= nxt_bin ^ (nxt_bin >> 1);
      end
   end
endmodule

// File: rtl/gfm_sync_bus.sv
`timescale 1ns/1ps
module gfm_sync_bus #(
   parameter int unsigned W      = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk) begin
      if (rst) begin
         stg <= '0;
      end else begin
         stg <= {stg[STAGES-2:0], d_i};
      end
   end

   assign q_o = stg[STAGES-1];
endmodule

// File: rtl/gfm_timebase.sv
`timescale 1ns/1ps
module gfm_timebase #(
   parameter int unsigned WINDOW_CYC  = 200,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   output logic req_tgl,
   output logic cap_pulse
);
   localparam int unsigned TB_W = (WINDOW_CYC > 2) ? $clog2(WINDOW_CYC) : 1;
   localparam logic [TB_W-1:0] TB_LAST = TB_W'(WINDOW_CYC - 1);

   logic [TB_W-1:0]        tb_cnt;
   logic                   tick;
   logic [SYNC_STAGES-1:0] cap_dly;

   assign tick = (tb_cnt == TB_LAST);

   always_ff @(posedge clk) begin
      if (rst) begin
         tb_cnt  <= '0;
         req_tgl <= 1'b0;
         cap_dly <= '0;
      end else begin
         tb_cnt  <= tick ? '0 : tb_cnt + TB_W'(1);
         req_tgl <= req_tgl ^ tick;
         cap_dly <= {cap_dly[SYNC_STAGES-2:0], tick};
      end
   end

   // capture once the count sampled at the request edge has crossed over
   assign cap_pulse = cap_dly[SYNC_STAGES-1];
endmodule

// File: rtl/gray_freq_meter.sv
`timescale 1ns/1ps
module gray_freq_meter #(
   parameter int unsigned CNT_W          = 10,
   parameter int unsigned WINDOW_CYC     = 200,
   parameter int unsigned SYNC_STAGES    = 2,
   parameter bit          BIN_AT_CAPTURE = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             evt_in,
   output logic [CNT_W-1:0] freq_bin,
   output logic             freq_vld
);
   import gfm_pkg::*;

   if (CNT_W < 2) begin : g_bad_width
      $error("gray_freq_meter: CNT_W must be at least 2");
   end
   if (SYNC_STAGES < GFM_MIN_SYNC) begin : g_bad_sync
      $error("gray_freq_meter: SYNC_STAGES below minimum");
   end
   if (WINDOW_CYC < gfm_min_window(SYNC_STAGES)) begin : g_bad_window
      $error("gray_freq_meter: WINDOW_CYC too short for the restart path");
   end
   if ((64'd1 << CNT_W) <= 64'(gfm_restart_credit(SYNC_STAGES))) begin : g_bad_credit
      $error("gray_freq_meter: CNT_W cannot hold the restart credit");
   end

   logic [CNT_W-1:0] cnt_gray;
   logic             x_restart;
   logic             req_tgl;
   logic             cap_pulse;
   logic [CNT_W-1:0] gray_sync;

   gfm_gray_counter #(.W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_cnt (
      .evt_clk  (evt_in),
      .arst     (rst),
      .req_tgl  (req_tgl),
      .cnt_gray (cnt_gray),
      .restart  (x_restart)
   );

   gfm_sync_bus #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .d_i (cnt_gray),
      .q_o (gray_sync)
   );

   gfm_timebase #(.WINDOW_CYC(WINDOW_CYC), .SYNC_STAGES(SYNC_STAGES)) u_tb (
      .clk       (clk),
      .rst       (rst),
      .req_tgl   (req_tgl),
      .cap_pulse (cap_pulse)
   );

   if (BIN_AT_CAPTURE) begin : g_dec_before
      // decode ahead of the readout register; output comes straight from a flop
      logic [CNT_W-1:0] sync_bin;
      logic [CNT_W-1:0] bin_hold;

      gfm_gray2bin #(.W(CNT_W)) u_dec (
         .gray_i (gray_sync),
         .bin_o  (sync_bin)
      );

      always_ff @(posedge clk) begin
         if (rst) begin
            bin_hold <= '0;
         end else if (cap_pulse) begin
            bin_hold <= sync_bin;
         end
      end

      assign freq_bin = bin_hold;
   end else begin : g_dec_after
      // hold the Gray word; decode on the output side
      logic [CNT_W-1:0] gray_hold;

      always_ff @(posedge clk) begin
         if (rst) begin
            gray_hold <= '0;
         end else if (cap_pulse) begin
            gray_hold <= gray_sync;
         end
      end

      gfm_gray2bin #(.W(CNT_W)) u_dec (
         .gray_i (gray_hold),
         .bin_o  (freq_bin)
      );
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         freq_vld <= 1'b0;
      end else begin
         freq_vld <= cap_pulse;
      end
   end
endmodule

// File: rtl/gfm_checker.sv
`timescale 1ns/1ps
module gfm_checker #(
   parameter int unsigned CNT_W       = 10,
   parameter int unsigned WINDOW_CYC  = 200,
   parameter int unsigned SYNC_STAGES = 2
) (
   input logic             clk,
   input logic             rst,
   input logic             evt_in,
   input logic [CNT_W-1:0] freq_bin,
   input logic             freq_vld,
   input logic [CNT_W-1:0] cnt_gray,
   input logic             x_restart
);
   localparam logic [CNT_W-1:0] CREDIT_BIN  = CNT_W'(SYNC_STAGES + 1);
   localparam logic [CNT_W-1:0] CREDIT_GRAY = CREDIT_BIN ^ (CREDIT_BIN >> 1);

   logic [31:0] gap;
   logic        seen;

   always_ff @(posedge clk) begin
      if (rst) begin
         gap  <= '0;
         seen <= 1'b0;
      end else if (freq_vld) begin
         gap  <= '0;
         seen <= 1'b1;
      end else begin
         gap  <= gap + 32'd1;
      end
   end

   assert_gray_step_R1: assert property (@(posedge evt_in) disable iff (rst)
      !x_restart |=> ($countones(cnt_gray ^ $past(cnt_gray)) == 1));

   assert_vld_gap_R3: assert property (@(posedge clk) disable iff (rst)
      (freq_vld && seen) |-> (gap == 32'(WINDOW_CYC - 1)));

   assert_vld_single_R4: assert property (@(posedge clk) disable iff (rst)
      freq_vld |=> !freq_vld);

   assert_bin_hold_R5: assert property (@(posedge clk) disable iff (rst)
      !freq_vld |-> $stable(freq_bin));

   assert_reset_clear_R6: assert property (@(posedge clk)
      rst |=> ((freq_bin == '0) && !freq_vld));

   assert_restart_load_R7: assert property (@(posedge evt_in) disable iff (rst)
      x_restart |=> (cnt_gray == CREDIT_GRAY));
endmodule

bind gray_freq_meter gfm_checker #(
   .CNT_W       (CNT_W),
   .WINDOW_CYC  (WINDOW_CYC),
   .SYNC_STAGES (SYNC_STAGES)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .evt_in    (evt_in),
   .freq_bin  (freq_bin),
   .freq_vld  (freq_vld),
   .cnt_gray  (cnt_gray),
   .x_restart (x_restart)
);

// File: tb/gray_freq_meter_test.sv
`timescale 1ns/1ps
module gray_freq_meter_test;
   localparam int CLK_PERIOD = 10;
   localparam int W          = 10;
   localparam int WIN        = 200;
   localparam int S          = 2;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         evt_in = 1'b0;
   logic [W-1:0] freq_bin;
   logic         freq_vld;

   int  checks = 0;
   int  failures = 0;
   int  cyc = 0;
   bit  done = 1'b0;
   real x_period = 20.0;

   int  exp_q[$];
   int  skip_n = 0;
   int  prev_pop = -1;
   int  last_vld_cyc = 0;
   bit  have_vld = 1'b0;
   bit  prev_vld = 1'b0;
   bit  hold_bad = 1'b0;
   int  last_bin = 0;

   gray_freq_meter #(.CNT_W(W), .WINDOW_CYC(WIN), .SYNC_STAGES(S)) uut (
      .clk      (clk),
      .rst      (rst),
      .evt_in   (evt_in),
      .freq_bin (freq_bin),
      .freq_vld (freq_vld)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   // event source: fractional phase keeps its edges off clock edges
   initial begin
      #3.3;
      forever begin
         evt_in = 1'b1;
         #(x_period/2.0);
         evt_in = 1'b0;
         #(x_period/2.0);
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // monitor: compares each reading against the scoreboard queue
   always @(negedge clk) begin
      if (rst) begin
         have_vld = 1'b0;
         prev_vld = 1'b0;
         hold_bad = 1'b0;
         last_bin = 0;
      end else begin
         if (freq_vld) begin
            chk(!prev_vld, "R4 strobe single cycle", int'(prev_vld), 0);
            if (have_vld)
               chk(cyc - last_vld_cyc == WIN, "R3 strobe spacing", cyc - last_vld_cyc, WIN);
            chk(!hold_bad, "R5 hold between strobes", int'(hold_bad), 0);
            have_vld = 1'b1;
            last_vld_cyc = cyc;
            hold_bad = 1'b0;
            if (skip_n > 0) begin
               skip_n--;
            end else if (exp_q.size() > 0) begin
               int e;
               int g;
               e = exp_q.pop_front();
               g = int'(freq_bin);
               chk((g >= e - 1) && (g <= e + 1), "R2 reading", g, e);
               if (prev_pop >= 0)
                  chk((g >= prev_pop - 1) && (g <= prev_pop + 1), "R7 no accumulation", g, prev_pop);
               prev_pop = g;
            end
         end else if (int'(freq_bin) != last_bin) begin
            hold_bad = 1'b1;
         end
         last_bin = int'(freq_bin);
         prev_vld = freq_vld;
      end
   end

   // driver: sets a rate and pushes the readings it should produce
   task automatic run_rate(input int period_ns, input int nwin);
      x_period = real'(period_ns);
      skip_n = 2;
      prev_pop = -1;
      for (int i = 0; i < nwin; i++) exp_q.push_back((WIN * CLK_PERIOD) / period_ns);
      while (exp_q.size() != 0) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      skip_n = 2;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(freq_bin == '0, "R6 reading cleared", int'(freq_bin), 0);
      chk(!freq_vld, "R6 strobe cleared", int'(freq_vld), 0);
      rst = 1'b0;
      begin
         int n;
         n = 0;
         while (n < 1000) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (freq_vld) break;
         end
         chk(n == WIN + S, "R6 first strobe delay", n, WIN + S);
      end
   endtask

   initial begin
      do_reset();
      run_rate(20, 3);
      run_rate(25, 3);
      run_rate(16, 3);
      run_rate(40, 3);
      run_rate(50, 2);
      do_reset();
      run_rate(80, 2);
      run_rate(20, 2);
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule